// File: doc/BRIEF.md
# Register Bus Target with Attention Requests

This block is a bus target that sits behind a register-bus master. It decodes an 8-bit address and owns a window of eight 16-bit locations at a base address set by a parameter. The window holds four plain storage words and one slow word, which stretches every access with a busy response for a programmable number of clocks. It also holds a wait-length setting, a write-only attention trigger and a word whose low three bits drive a set of status flags back to the master.

All response outputs depend only on the current request and the stored state. They are held at zero whenever this target is not addressed, so several targets can be OR-combined onto one response bus. An init pulse with the write-enable high, sent to this window, clears the target. The master samples 16 attention lines as one-cycle set requests. A write to the trigger word produces such a one-cycle pulse on the matching bits.

Top module: `rbt_target`

## Requirements
- R1: While reset is high and in the first cycle after it, every response output, the attention lines and the status flags are zero. Each storage word then reads back as zero.
- R2: A read cycle (m_req=1, m_we=0, m_init=0) whose address lies in the window [BASE_ADDR, BASE_ADDR+7] returns s_ack=1 in the same cycle. For every offset except the slow word (offset 4), s_busy is 0 and s_rdata is the stored word. Offsets 0 to 3 are the plain words.
- R3: A write cycle (m_req=1, m_we=1, m_init=0) to the window is acknowledged in the same cycle. It stores m_wdata at the clock edge that ends the cycle, and a read in the next cycle returns the new value.
- R4: A request outside the window gets s_ack, s_busy and s_err at 0 and s_rdata at zero. It changes no stored word.
- R5: s_rdata is zero in every cycle in which s_ack is not 1 together with s_busy at 0. This includes write cycles and stretched cycles.
- R6: Let N be the wait setting at offset 5. An access to offset 4 holds s_busy=1 with s_ack=1 for exactly N consecutive cycles while the request is held. The next cycle completes it with s_busy=0. A write to offset 4 takes effect only in that final cycle. N=0 gives a single-cycle access, and the largest N (2^DLY_W-1) completes within 2^DLY_W cycles.
- R7: The wait setting at offset 5 keeps only its low DLY_W bits (5 by default). Its upper bits read back as zero.
- R8: A write to offset 6 drives attn_set equal to m_wdata for exactly the one cycle after the write. At all other times attn_set is zero.
- R9: A read of offset 6 is answered with s_ack=1, s_err=1 and s_rdata zero. s_err is 0 in every other cycle.
- R10: An external init (m_init=1, m_we=1, m_req=0) addressed to the window clears every stored word and the status flags. An internal init (m_we=0), or an init outside the window, changes nothing. No response output is asserted during any init cycle.
- R11: stat_flags always equals bits 2:0 of the word at offset 7.
- R12: A cycle with m_req and m_init both high is illegal. It gets no response and changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 1 | Master requests a read or write access |
| m_we | input | 1 | Write enable; also selects external init |
| m_init | input | 1 | Init pulse |
| m_addr | input | 8 | Register address |
| m_wdata | input | 16 | Write data |
| s_ack | output | 1 | Address accepted by this target |
| s_busy | output | 1 | Access is being stretched |
| s_err | output | 1 | Access error |
| s_rdata | output | 16 | Read data, valid only on completion |
| attn_set | output | 16 | One-cycle attention set requests |
| stat_flags | output | 3 | Status flags reported to the master |

## Verification
The bench goes after the slow word's stretch length at zero, three and the maximum setting. A wrong counter would show up as one busy cycle too many or too few, which the master would record as a timeout or as early data. It checks that a stretched write leaves the old value in place until the last cycle, and that read data stays zero while busy is high. A leak there would hand the master a stale word. It also sends an internal init, an init outside the window and a request that collides with an init. A target that decoded the cycle type from fewer bits would wipe or overwrite its storage, and the bench catches this by reading the words back afterwards.

// File: rtl/rbt_pkg.sv
package rbt_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 16;
    localparam int ATTN_W    = 16;
    localparam int FLAG_W    = 3;
    localparam int OFS_W     = 3;
    localparam int NUM_PLAIN = 4;

    typedef enum logic [OFS_W-1:0] {
        OFS_D0   = 3'd0,
        OFS_D1   = 3'd1,
        OFS_D2   = 3'd2,
        OFS_D3   = 3'd3,
        OFS_SLOW = 3'd4,
        OFS_WAIT = 3'd5,
        OFS_TRIG = 3'd6,
        OFS_FLAG = 3'd7
    } rbt_ofs_e;

    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_READ,
        CYC_WRITE,
        CYC_INIT_INT,
        CYC_INIT_EXT,
        CYC_ILLEGAL
    } rbt_cyc_e;

    typedef struct packed {
        rbt_cyc_e cyc;
        logic     hit;
        rbt_ofs_e ofs;
    } rbt_access_t;

    // Cycle type from the request, write-enable and init bits taken together.
    function automatic rbt_cyc_e cycle_kind(input logic req, input logic we,
                                            input logic init);
        rbt_cyc_e k;
        if (req && init)
            k = CYC_ILLEGAL;
        else if (init)
            k = we ? CYC_INIT_EXT : CYC_INIT_INT;
        else if (req)
            k = we ? CYC_WRITE : CYC_READ;
        else
            k = CYC_IDLE;
        return k;
    endfunction

endpackage

// File: rtl/rbt_decode.sv
module rbt_decode
    import rbt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input  logic              req,
    input  logic              we,
    input  logic              init,
    input  logic [ADDR_W-1:0] addr,
    output rbt_access_t       acc
);
    localparam int TAG_W = ADDR_W - OFS_W;

    always_comb begin
        acc.cyc = cycle_kind(req, we, init);
        acc.hit = (addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
        acc.ofs = rbt_ofs_e'(addr[OFS_W-1:0]);
    end

    // The window must start on an aligned boundary.
    initial begin
        if (BASE_ADDR[OFS_W-1:0] != '0)
            $error("BASE_ADDR must be aligned to the %0d-word window", 1 << OFS_W);
        if (TAG_W < 1)
            $error("address too narrow for the window");
    end

endmodule

// File: rtl/rbt_stretch.sv
module rbt_stretch #(
    parameter int DLY_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [DLY_W-1:0] wait_len,
    output logic             busy,
    output logic             done
);
    logic [DLY_W-1:0] cnt_q;

    assign busy = active && (cnt_q != wait_len);
    assign done = active && !busy;

    always_ff @(posedge clk) begin
        if (rst || !active)
            cnt_q <= '0;
        else if (busy)
            cnt_q <= cnt_q + DLY_W'(1);
        else
            cnt_q <= '0;
    end

endmodule

// File: rtl/rbt_regfile.sv
module rbt_regfile
    import rbt_pkg::*;
#(
    parameter int DLY_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_en,
    input  rbt_ofs_e          wr_ofs,
    input  logic [DATA_W-1:0] wr_data,
    input  rbt_ofs_e          rd_ofs,
    output logic [DATA_W-1:0] rd_data,
    output logic [DLY_W-1:0]  wait_len,
    output logic [FLAG_W-1:0] flags
);
    logic [DATA_W-1:0] plain_q [NUM_PLAIN];
    logic [DATA_W-1:0] slow_q;
    logic [DLY_W-1:0]  wait_q;
    logic [FLAG_W-1:0] flag_q;

    for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
        always_ff @(posedge clk) begin
            if (rst || clear)
                plain_q[g] <= '0;
            else if (wr_en && (wr_ofs == rbt_ofs_e'(g)))
                plain_q[g] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            slow_q <= '0;
            wait_q <= '0;
            flag_q <= '0;
        end else if (wr_en) begin
            case (wr_ofs)
                OFS_SLOW: slow_q <= wr_data;
                OFS_WAIT: wait_q <= wr_data[DLY_W-1:0];
                OFS_FLAG: flag_q <= wr_data[FLAG_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (rd_ofs)
            OFS_D0:   rd_data = plain_q[0];
            OFS_D1:   rd_data = plain_q[1];
            OFS_D2:   rd_data = plain_q[2];
            OFS_D3:   rd_data = plain_q[3];
            OFS_SLOW: rd_data = slow_q;
            OFS_WAIT: rd_data = {{(DATA_W-DLY_W){1'b0}}, wait_q};
            OFS_FLAG: rd_data = {{(DATA_W-FLAG_W){1'b0}}, flag_q};
            default:  rd_data = '0;
        endcase
    end

    assign wait_len = wait_q;
    assign flags    = flag_q;

endmodule

// File: rtl/rbt_attn.sv
module rbt_attn
    import rbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [ATTN_W-1:0] bits,
    output logic [ATTN_W-1:0] attn
);
    logic [ATTN_W-1:0] attn_q;

    always_ff @(posedge clk) begin
        if (rst)
            attn_q <= '0;
        else
            attn_q <= fire ? bits : '0;
    end

    assign attn = attn_q;

endmodule

// File: rtl/rbt_target.sv
module rbt_target
    import rbt_pkg::*;
#(
    parameter logic [7:0] BASE_ADDR = 8'h40,
    parameter int         DLY_W     = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        m_req,
    input  logic        m_we,
    input  logic        m_init,
    input  logic [7:0]  m_addr,
    input  logic [15:0] m_wdata,
    output logic        s_ack,
    output logic        s_busy,
    output logic        s_err,
    output logic [15:0] s_rdata,
    output logic [15:0] attn_set,
    output logic [2:0]  stat_flags
);
    rbt_access_t       acc;
    logic              rd_hit, wr_hit, slow_sel, stretch_busy, stretch_done;
    logic              store_en, clear_all, trig_fire;
    logic [DATA_W-1:0] rd_word;
    logic [DLY_W-1:0]  wait_len;

    rbt_decode #(.BASE_ADDR(BASE_ADDR)) u_decode (
        .req  (m_req),
        .we   (m_we),
        .init (m_init),
        .addr (m_addr),
        .acc  (acc)
    );

    assign rd_hit    = (acc.cyc == CYC_READ)  && acc.hit;
    assign wr_hit    = (acc.cyc == CYC_WRITE) && acc.hit;
    assign slow_sel  = (rd_hit || wr_hit) && (acc.ofs == OFS_SLOW);
    assign clear_all = (acc.cyc == CYC_INIT_EXT) && acc.hit;
    assign trig_fire = wr_hit && (acc.ofs == OFS_TRIG);

    rbt_stretch #(.DLY_W(DLY_W)) u_stretch (
        .clk      (clk),
        .rst      (rst),
        .active   (slow_sel),
        .wait_len (wait_len),
        .busy     (stretch_busy),
        .done     (stretch_done)
    );

    // Slow word commits only on its completing cycle; the rest at once.
    assign store_en = wr_hit && (!slow_sel || stretch_done);

    rbt_regfile #(.DLY_W(DLY_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear_all),
        .wr_en    (store_en),
        .wr_ofs   (acc.ofs),
        .wr_data  (m_wdata),
        .rd_ofs   (acc.ofs),
        .rd_data  (rd_word),
        .wait_len (wait_len),
        .flags    (stat_flags)
    );

    rbt_attn u_attn (
        .clk  (clk),
        .rst  (rst),
        .fire (trig_fire),
        .bits (m_wdata),
        .attn (attn_set)
    );

    assign s_ack   = rd_hit || wr_hit;
    assign s_busy  = stretch_busy;
    assign s_err   = rd_hit && (acc.ofs == OFS_TRIG);
    assign s_rdata = (rd_hit && !stretch_busy) ? rd_word : '0;

endmodule

// File: rtl/rbt_target_chk.sv
module rbt_target_chk #(
    parameter logic [7:0] BASE_ADDR = 8'h40,
    parameter int         DLY_W     = 5
) (
    input logic        clk,
    input logic        rst,
    input logic        m_req,
    input logic        m_we,
    input logic        m_init,
    input logic [7:0]  m_addr,
    input logic [15:0] m_wdata,
    input logic        s_ack,
    input logic        s_busy,
    input logic        s_err,
    input logic [15:0] s_rdata,
    input logic [15:0] attn_set,
    input logic [2:0]  stat_flags
);
    localparam int RUN_W   = DLY_W + 1;
    localparam int RUN_MAX = (1 << DLY_W) - 1;

    logic             in_win;
    logic [RUN_W-1:0] busy_run;

    assign in_win = (m_addr[7:3] == BASE_ADDR[7:3]);

    always_ff @(posedge clk) begin
        if (rst || !s_busy)
            busy_run <= '0;
        else
            busy_run <= busy_run + RUN_W'(1);
    end

    AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(m_req && in_win) |-> (!s_ack && !s_busy && !s_err && s_rdata == 16'h0)); // R4

    AST_RDATA_GATED: assert property (@(posedge clk) disable iff (rst)
        !(s_ack && !s_busy) |-> (s_rdata == 16'h0)); // R5

    AST_BUSY_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        s_busy |-> s_ack); // R6

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        s_busy |-> (int'(busy_run) < RUN_MAX)); // R6

    AST_ATTN_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        (attn_set != 16'h0) |-> $past(m_req && m_we && !m_init && in_win
                                      && m_addr[2:0] == 3'd6)); // R8

    AST_ERR_ONLY_TRIG_READ: assert property (@(posedge clk) disable iff (rst)
        s_err |-> (m_req && !m_we && !m_init && in_win && m_addr[2:0] == 3'd6)); // R9

    AST_INIT_SILENT: assert property (@(posedge clk) disable iff (rst)
        m_init |-> (!s_ack && !s_busy && !s_err)); // R10

    AST_WRITE_NO_RDATA: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_we) |-> (s_rdata == 16'h0 && m_wdata == m_wdata)); // R5

endmodule

bind rbt_target rbt_target_chk #(.BASE_ADDR(BASE_ADDR), .DLY_W(DLY_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .m_req      (m_req),
    .m_we       (m_we),
    .m_init     (m_init),
    .m_addr     (m_addr),
    .m_wdata    (m_wdata),
    .s_ack      (s_ack),
    .s_busy     (s_busy),
    .s_err      (s_err),
    .s_rdata    (s_rdata),
    .attn_set   (attn_set),
    .stat_flags (stat_flags)
);

// File: tb/rbt_target_tb.sv
module rbt_target_tb;
    localparam logic [7:0] BASE = 8'h40;

    logic        clk = 1'b0;
    logic        rst;
    logic        m_req, m_we, m_init;
    logic [7:0]  m_addr;
    logic [15:0] m_wdata;
    logic        s_ack, s_busy, s_err;
    logic [15:0] s_rdata, attn_set;
    logic [2:0]  stat_flags;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rbt_target #(.BASE_ADDR(BASE), .DLY_W(5)) u_dut (
        .clk(clk), .rst(rst), .m_req(m_req), .m_we(m_we), .m_init(m_init),
        .m_addr(m_addr), .m_wdata(m_wdata), .s_ack(s_ack), .s_busy(s_busy),
        .s_err(s_err), .s_rdata(s_rdata), .attn_set(attn_set),
        .stat_flags(stat_flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_idle();
        m_req = 0; m_we = 0; m_init = 0; m_addr = 8'h00; m_wdata = 16'h0;
    endtask

    // Drive at the falling edge, sample 5 ns later, well before the rising edge.
    task automatic drive(input logic req, input logic we, input logic init,
                         input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        m_req = req; m_we = we; m_init = init; m_addr = a; m_wdata = d;
        #5;
    endtask

    task automatic wr(input string tag, input logic [7:0] a, input logic [15:0] d,
                      input logic exp_ack);
        drive(1, 1, 0, a, d);
        chk({tag, " write ack"}, {31'b0, s_ack}, {31'b0, exp_ack});
        chk({tag, " R5 write rdata"}, {16'b0, s_rdata}, 32'h0);
        @(negedge clk); bus_idle();
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic exp_ack,
                      input logic [15:0] exp_d);
        drive(1, 0, 0, a, 16'h0);
        chk({tag, " read ack"}, {31'b0, s_ack}, {31'b0, exp_ack});
        chk({tag, " read data"}, {16'b0, s_rdata}, {16'b0, exp_d});
        @(negedge clk); bus_idle();
    endtask

    task automatic t_reset();
        bus_idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); #5;
        chk("R1 ack in reset", {31'b0, s_ack}, 32'h0);
        chk("R1 attn in reset", {16'b0, attn_set}, 32'h0);
        rst = 0;
        @(negedge clk); #5;
        chk("R1 flags after reset", {29'b0, stat_flags}, 32'h0);
        chk("R1 busy after reset", {31'b0, s_busy}, 32'h0);
        for (int i = 0; i < 6; i++) rd("R1 word", BASE + 8'(i), 1'b1, 16'h0);
    endtask

    task automatic t_plain();
        wr("R3 d0", BASE + 8'd0, 16'hA5C3, 1'b1);
        wr("R3 d3", BASE + 8'd3, 16'h0F0F, 1'b1);
        rd("R2 d0", BASE + 8'd0, 1'b1, 16'hA5C3);
        rd("R2 d3", BASE + 8'd3, 1'b1, 16'h0F0F);
        rd("R2 d1", BASE + 8'd1, 1'b1, 16'h0000);
        drive(1, 0, 0, BASE + 8'd2, 16'h0);
        chk("R2 busy plain", {31'b0, s_busy}, 32'h0);
        @(negedge clk); bus_idle();
    endtask

    task automatic t_foreign();
        wr("R4 foreign", 8'h48, 16'h1111, 1'b0);
        wr("R4 foreign low", 8'h3F, 16'h2222, 1'b0);
        drive(1, 0, 0, 8'h48, 16'h0);
        chk("R4 foreign busy/err", {30'b0, s_busy, s_err}, 32'h0);
        chk("R4 foreign rdata", {16'b0, s_rdata}, 32'h0);
        @(negedge clk); bus_idle();
        rd("R4 d0 intact", BASE + 8'd0, 1'b1, 16'hA5C3);
    endtask

    task automatic t_wait_mask();
        wr("R7 wait", BASE + 8'd5, 16'hFFE3, 1'b1);
        rd("R7 wait masked", BASE + 8'd5, 1'b1, 16'h0003);
    endtask

    // Holds a slow access until busy drops; returns the count of busy cycles.
    task automatic slow_access(input string tag, input logic we, input logic [15:0] d,
                               input int n_exp, input logic [15:0] exp_d);
        int n_busy = 0;
        drive(1, we, 0, BASE + 8'd4, d);
        while (s_busy && n_busy < 40) begin
            chk({tag, " R6 ack while busy"}, {31'b0, s_ack}, 32'h1);
            chk({tag, " R5 rdata while busy"}, {16'b0, s_rdata}, 32'h0);
            n_busy++;
            @(negedge clk); #5;
        end
        chk({tag, " R6 busy cycles"}, n_busy, n_exp);
        chk({tag, " R6 final ack"}, {31'b0, s_ack}, 32'h1);
        if (!we) chk({tag, " R6 final data"}, {16'b0, s_rdata}, {16'b0, exp_d});
        @(negedge clk); bus_idle();
    endtask

    task automatic t_slow();
        // wait setting is 3 from the previous scenario
        // abort a stretched write after two cycles: old value must remain
        drive(1, 1, 0, BASE + 8'd4, 16'hDEAD);
        chk("R6 busy on abort", {31'b0, s_busy}, 32'h1);
        @(negedge clk); #5;
        @(negedge clk); bus_idle(); #5;
        slow_access("R6 rd after abort", 1'b0, 16'h0, 3, 16'h0000);
        slow_access("R6 wr", 1'b1, 16'hBEEF, 3, 16'h0);
        slow_access("R6 rd", 1'b0, 16'h0, 3, 16'hBEEF);
        wr("R6 wait0", BASE + 8'd5, 16'h0000, 1'b1);
        slow_access("R6 zero wait", 1'b0, 16'h0, 0, 16'hBEEF);
        wr("R6 waitmax", BASE + 8'd5, 16'h001F, 1'b1);
        slow_access("R6 max wait", 1'b0, 16'h0, 31, 16'hBEEF);
        wr("R6 wait restore", BASE + 8'd5, 16'h0000, 1'b1);
    endtask

    task automatic t_attn();
        chk("R8 attn idle", {16'b0, attn_set}, 32'h0);
        drive(1, 1, 0, BASE + 8'd6, 16'h8001);
        chk("R8 trig ack", {31'b0, s_ack}, 32'h1);
        chk("R8 attn not yet", {16'b0, attn_set}, 32'h0);
        @(negedge clk); bus_idle(); #5;
        chk("R8 attn pulse", {16'b0, attn_set}, 32'h8001);
        @(negedge clk); #5;
        chk("R8 attn cleared", {16'b0, attn_set}, 32'h0);
    endtask

    task automatic t_err();
        drive(1, 0, 0, BASE + 8'd6, 16'h0);
        chk("R9 trig read ack/err", {30'b0, s_ack, s_err}, 32'h3);
        chk("R9 trig read data", {16'b0, s_rdata}, 32'h0);
        @(negedge clk); bus_idle();
        drive(1, 0, 0, BASE + 8'd1, 16'h0);
        chk("R9 no err elsewhere", {31'b0, s_err}, 32'h0);
        @(negedge clk); bus_idle();
    endtask

    task automatic t_flags();
        wr("R11 flags", BASE + 8'd7, 16'hFFF5, 1'b1);
        @(negedge clk); #5;
        chk("R11 stat_flags", {29'b0, stat_flags}, 32'h5);
        rd("R11 flag word", BASE + 8'd7, 1'b1, 16'h0005);
    endtask

    task automatic t_clash();
        drive(1, 1, 1, BASE + 8'd1, 16'h5555);
        chk("R12 clash no ack", {31'b0, s_ack}, 32'h0);
        @(negedge clk); bus_idle();
        rd("R12 d1 unchanged", BASE + 8'd1, 1'b1, 16'h0000);
        rd("R12 d0 unchanged", BASE + 8'd0, 1'b1, 16'hA5C3);
    endtask

    task automatic t_init();
        drive(0, 0, 1, BASE, 16'h0);
        chk("R10 internal init silent", {29'b0, s_ack, s_busy, s_err}, 32'h0);
        @(negedge clk); bus_idle();
        rd("R10 kept after internal", BASE + 8'd0, 1'b1, 16'hA5C3);
        drive(0, 1, 1, 8'h90, 16'h0);
        @(negedge clk); bus_idle();
        rd("R10 kept after foreign init", BASE + 8'd0, 1'b1, 16'hA5C3);
        drive(0, 1, 1, BASE + 8'd2, 16'h0);
        chk("R10 external init silent", {29'b0, s_ack, s_busy, s_err}, 32'h0);
        @(negedge clk); bus_idle(); #5;
        chk("R10 flags cleared", {29'b0, stat_flags}, 32'h0);
        rd("R10 d0 cleared", BASE + 8'd0, 1'b1, 16'h0000);
        rd("R10 d3 cleared", BASE + 8'd3, 1'b1, 16'h0000);
        rd("R10 slow cleared", BASE + 8'd4, 1'b1, 16'h0000);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        summary();
    end

    initial begin
        t_reset();
        t_plain();
        t_foreign();
        t_wait_mask();
        t_slow();
        t_attn();
        t_err();
        t_flags();
        t_clash();
        t_init();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule